// File: doc/BRIEF.md
# BCD up/down decade digit

A single decimal digit held as a 4-bit BCD value. On each rising clock edge it steps up or down by one, if its active-low enable is low. It wraps from nine to zero going up and from zero to nine going down. A high on the clear input forces the digit to zero at once. A high on the load input copies the data input into the digit with no clock edge needed. While load stays high the digit keeps tracking the data input. When load is released, the last value seen is kept.

The active-low terminal-count output is decoded from the present digit, the direction and the enable. Several digits form a multi-digit decimal counter when each digit's terminal count drives the next digit's enable. All digits share the same clock, direction, clear and load. A carry or borrow then reaches the next digit within the same clock cycle, and both digits change on the same edge.

Top module: `bcd_updown_digit`

## Requirements
- R1: While clear_i is high, count_o is 0000 at once and without a clock edge. This holds whatever the states of load_i, up_i and cnt_en_n_i, and clear_i outranks load_i.
- R2: While load_i is high and clear_i is low, count_o equals data_i and follows its changes without a clock edge. Clock edges in this time have no effect. When load_i falls, the last loaded value stays until the next counting edge.
- R3: With clear_i and load_i low and cnt_en_n_i high, a rising clock edge leaves count_o unchanged.
- R4: With up_i = 1 and cnt_en_n_i low, each rising clock edge adds one to count_o, and 9 goes to 0.
- R5: With up_i = 0 and cnt_en_n_i low, each rising clock edge subtracts one from count_o, and 0 goes to 9.
- R6: From a non-decimal value (10 to 15), the next enabled edge gives 0 when counting up and 9 when counting down.
- R7: term_n_o is 0 when cnt_en_n_i is low, up_i = 1, and count_o bit 0 and bit 3 are both 1. Within the decimal range this means the digit is 9.
- R8: term_n_o is 0 when cnt_en_n_i is low, up_i = 0 and count_o is 0000.
- R9: term_n_o is 1 in every other case, and always while cnt_en_n_i is high.
- R10: term_n_o is combinational. A digit whose cnt_en_n_i is driven by a lower digit's term_n_o steps on the same edge as that lower digit's wrap.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge |
| clear_i | input | 1 | Asynchronous clear to zero, active high, highest priority |
| load_i | input | 1 | Asynchronous level-held load, active high |
| data_i | input | 4 | Value to load |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| cnt_en_n_i | input | 1 | Count enable, active low |
| count_o | output | 4 | Present BCD digit |
| term_n_o | output | 1 | Terminal count (carry/borrow), active low |

## Verification
Counting results appear on count_o just after the rising edge that causes them. The bench compares them two time units after that edge, before it drives any input again. Clear and load act with no clock, and term_n_o follows its inputs combinationally. For these, the bench triggers the comparison a unit after the stimulus and inside the low half of the clock, so no edge falls between stimulus and sample. Three digits are chained terminal-count to enable, and their joint value is compared with a decimal model, so carries and borrows are checked on the same edge as the wrap that causes them.

// File: rtl/bcd_pkg.sv
// Shared constants and types for the BCD digit.
// Assumes one decimal digit stored in a 4-bit field.
package bcd_pkg;
    localparam int DIG_W    = 4;
    localparam int DIG_LAST = 9;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/bcd_next_value.sv
// Next-value logic for one digit: steps up or down with decimal wrap.
// Values above LAST go to 0 when counting up and to LAST when counting down.
// Assumes the caller decides whether the step is taken.
module bcd_next_value #(
    parameter int W    = bcd_pkg::DIG_W,
    parameter int LAST = bcd_pkg::DIG_LAST
) (
    input  logic [W-1:0] cur_i,
    input  logic         up_i,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] LAST_V = W'(LAST);
    localparam logic [W-1:0] ONE_V  = W'(1);

    // Pick the successor or the predecessor with wrap.
    always_comb begin
        if (up_i == bcd_pkg::DIR_UP) begin
            nxt_o = (cur_i >= LAST_V) ? '0 : cur_i + ONE_V;
        end else begin
            nxt_o = (cur_i == '0 || cur_i > LAST_V) ? LAST_V : cur_i - ONE_V;
        end
    end
endmodule

// File: rtl/bcd_term_decode.sv
// Active-low terminal-count decode for one digit.
// Going up it looks at bit 0 and the top bit (the value nine); going down it looks for zero.
// It is purely combinational, so the decode can drive the next digit's enable.
module bcd_term_decode #(
    parameter int W = bcd_pkg::DIG_W
) (
    input  logic [W-1:0] cur_i,
    input  logic         up_i,
    input  logic         en_n_i,
    output logic         term_n_o
);
    logic hit;

    // Detect the last value in the current direction.
    always_comb begin
        if (up_i == bcd_pkg::DIR_UP) hit = cur_i[0] & cur_i[W-1];
        else                         hit = (cur_i == '0);
    end

    // Output is gated by the enable and driven low when active.
    always_comb term_n_o = ~(~en_n_i & hit);
endmodule

// File: rtl/bcd_load_capture.sv
// Level-held asynchronous load capture.
// A transparent latch follows the data while load is high. A marker flag is set
// without a clock when load rises and is cleared by the first clock edge seen with
// load low. While the flag is set, the digit takes its value from the latch.
// Assumes clear outranks load.
module bcd_load_capture #(
    parameter int W = bcd_pkg::DIG_W
) (
    input  logic         clk_i,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] snap_o,
    output logic         use_snap_o
);
    // Transparent capture of the load data; clear forces zero.
    always_latch begin
        if (clear_i)     snap_o = '0;
        else if (load_i) snap_o = data_i;
    end

    // Marker: set at once by load, dropped by the next clock edge with load low.
    always_ff @(posedge clk_i or posedge load_i) begin
        if (load_i) use_snap_o <= 1'b1;
        else        use_snap_o <= 1'b0;
    end
endmodule

// File: rtl/bcd_updown_digit.sv
// One BCD up/down digit with asynchronous clear, level-held asynchronous load,
// active-low enable and active-low terminal count for chaining.
// Priority: clear, then load, then counting on the rising clock edge.
// Assumes clear and load are glitch-free levels from the surrounding logic.
module bcd_updown_digit #(
    parameter int W    = bcd_pkg::DIG_W,
    parameter int LAST = bcd_pkg::DIG_LAST
) (
    input  logic         clk_i,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         up_i,
    input  logic         cnt_en_n_i,
    output logic [W-1:0] count_o,
    output logic         term_n_o
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    logic [W-1:0] held_q;
    logic [W-1:0] snap;
    logic [W-1:0] nxt;
    logic         use_snap;

    bcd_load_capture #(.W(W)) u_cap (
        .clk_i      (clk_i),
        .clear_i    (clear_i),
        .load_i     (load_i),
        .data_i     (data_i),
        .snap_o     (snap),
        .use_snap_o (use_snap)
    );

    bcd_next_value #(.W(W), .LAST(LAST)) u_next (
        .cur_i (count_o),
        .up_i  (up_i),
        .nxt_o (nxt)
    );

    bcd_term_decode #(.W(W)) u_term (
        .cur_i    (count_o),
        .up_i     (up_i),
        .en_n_i   (cnt_en_n_i),
        .term_n_o (term_n_o)
    );

    // Visible digit: clear, then live load, then captured load, then stored count.
    always_comb begin
        if (clear_i)       count_o = '0;
        else if (load_i)   count_o = data_i;
        else if (use_snap) count_o = snap;
        else               count_o = held_q;
    end

    // Stored count: takes the visible digit, stepped if enabled, when not loading.
    always_ff @(posedge clk_i or posedge clear_i) begin
        if (clear_i)     held_q <= '0;
        else if (!load_i) held_q <= cnt_en_n_i ? count_o : nxt;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (clear_i)
        ($past(clear_i) && !load_i && !use_snap) |-> (count_o == '0)); // R1

    AST_LOAD_FOLLOW: assert property (@(posedge clk_i) disable iff (clear_i)
        load_i |-> (count_o == data_i)); // R2

    AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (clear_i)
        (!load_i && cnt_en_n_i) |=> (use_snap || count_o == $past(count_o))); // R3

    AST_UP_STEP: assert property (@(posedge clk_i) disable iff (clear_i)
        (!load_i && !cnt_en_n_i && up_i && count_o < LAST_V)
        |=> (use_snap || count_o == W'($past(count_o) + 1'b1))); // R4

    AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (clear_i)
        (!load_i && !cnt_en_n_i && up_i && count_o == LAST_V)
        |=> (use_snap || count_o == '0)); // R4

    AST_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (clear_i)
        (!load_i && !cnt_en_n_i && !up_i && count_o == '0)
        |=> (use_snap || count_o == LAST_V)); // R5

    AST_NONBCD_RECOVER: assert property (@(posedge clk_i) disable iff (clear_i)
        (!load_i && !cnt_en_n_i && count_o > LAST_V)
        |=> (use_snap || count_o == ($past(up_i) ? '0 : LAST_V))); // R6

    AST_TC_IDLE: assert property (@(posedge clk_i) disable iff (clear_i)
        cnt_en_n_i |-> term_n_o); // R9
endmodule

// File: tb/tb_bcd_updown_digit.sv
module tb_bcd_updown_digit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [11:0] cnt;
        logic [2:0]  tcn;
        string       req;
    } exp_t;

    logic       clk = 1'b0;
    logic       clear;
    logic       load;
    logic       up;
    logic       ce_n;
    logic [3:0] data_b [3];
    logic [3:0] cnt_b  [3];
    logic [2:0] tcn_b;
    logic [3:0] r [3];

    exp_t  sb[$];
    event  sample_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_updown_digit dut (
        .clk_i(clk), .clear_i(clear), .load_i(load), .data_i(data_b[0]),
        .up_i(up), .cnt_en_n_i(ce_n), .count_o(cnt_b[0]), .term_n_o(tcn_b[0]));
    bcd_updown_digit dut_mid (
        .clk_i(clk), .clear_i(clear), .load_i(load), .data_i(data_b[1]),
        .up_i(up), .cnt_en_n_i(tcn_b[0]), .count_o(cnt_b[1]), .term_n_o(tcn_b[1]));
    bcd_updown_digit dut_hi (
        .clk_i(clk), .clear_i(clear), .load_i(load), .data_i(data_b[2]),
        .up_i(up), .cnt_en_n_i(tcn_b[1]), .count_o(cnt_b[2]), .term_n_o(tcn_b[2]));

    // Reference decode of the active-low terminal count (R7, R8, R9).
    function automatic logic ref_tcn(input logic [3:0] v, input logic dir_up, input logic en);
        logic hit;
        hit = dir_up ? (v[0] & v[3]) : (v == 4'd0);
        return !(en && hit);
    endfunction

    // Reference single step (R4, R5, R6).
    function automatic logic [3:0] ref_step(input logic [3:0] v, input logic dir_up);
        if (dir_up) return (v >= 4'd9) ? 4'd0 : v + 4'd1;
        return (v == 4'd0 || v > 4'd9) ? 4'd9 : v - 4'd1;
    endfunction

    // Driver side: push the expected state of all three digits and fire the monitor.
    task automatic push_exp(input string req);
        exp_t e;
        logic en;
        if (clear)     for (int i = 0; i < 3; i++) r[i] = 4'd0;
        else if (load) for (int i = 0; i < 3; i++) r[i] = data_b[i];
        en = !ce_n;
        for (int i = 0; i < 3; i++) begin
            e.tcn[i] = ref_tcn(r[i], up, en);
            en = !e.tcn[i];
        end
        e.cnt = {r[2], r[1], r[0]};
        e.req = req;
        sb.push_back(e);
        -> sample_ev;
        #1;
    endtask

    task automatic check_now(input string req);
        #1;
        push_exp(req);
    endtask

    // One clock edge; the reference steps the chain with pre-edge values (R10).
    task automatic tick(input string req);
        logic en;
        logic nxt_en;
        @(posedge clk);
        if (!clear && !load) begin
            en = !ce_n;
            for (int i = 0; i < 3; i++) begin
                nxt_en = !ref_tcn(r[i], up, en);
                if (en) r[i] = ref_step(r[i], up);
                en = nxt_en;
            end
        end
        #2;
        push_exp(req);
    endtask

    // Short load pulse in the low half of the clock, no edge involved (R2).
    task automatic pulse_load(input logic [3:0] v2, input logic [3:0] v1,
                              input logic [3:0] v0, input string req);
        @(negedge clk);
        #1;
        data_b[2] = v2; data_b[1] = v1; data_b[0] = v0;
        load = 1'b1;
        #1;
        load = 1'b0;
        r[2] = v2; r[1] = v1; r[0] = v0;
        #1;
        push_exp(req);
    endtask

    // Monitor side: pop and compare whenever the driver signals a sample point.
    initial begin
        exp_t e;
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if ({cnt_b[2], cnt_b[1], cnt_b[0]} !== e.cnt || tcn_b !== e.tcn) begin
                    errors++;
                    $display("FAIL %s count=%h tc_n=%b expected count=%h tc_n=%b",
                             e.req, {cnt_b[2], cnt_b[1], cnt_b[0]}, tcn_b, e.cnt, e.tcn);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear = 1'b1; load = 1'b0; up = 1'b1; ce_n = 1'b1;
        for (int i = 0; i < 3; i++) begin data_b[i] = 4'd0; r[i] = 4'd0; end

        // R1: reset state
        tick("R1");
        tick("R1");
        clear = 1'b0;
        ce_n  = 1'b0;
        // R4 and R10: count up through 009 -> 010
        for (int k = 0; k < 12; k++) tick("R4 R10");

        // R2, R10: carry through two digits
        pulse_load(4'd0, 4'd9, 4'd9, "R2");
        tick("R10");
        // R7: all digits nine, chain fully low; then wrap of every digit
        pulse_load(4'd9, 4'd9, 4'd9, "R7");
        tick("R4");

        // R8: down at zero, borrow decode, then wrap to 999
        up = 1'b0;
        check_now("R8");
        tick("R5");
        pulse_load(4'd1, 4'd0, 4'd0, "R2");
        tick("R5 R10");
        for (int k = 0; k < 3; k++) tick("R5");

        // R3, R9: disabled digit holds, terminal count stays high
        ce_n = 1'b1;
        check_now("R9");
        for (int k = 0; k < 3; k++) tick("R3");
        pulse_load(4'd0, 4'd0, 4'd0, "R9");
        tick("R3 R9");
        ce_n = 1'b0;
        tick("R5");

        // R6: non-decimal values recover within one count
        up = 1'b1;
        pulse_load(4'd0, 4'd3, 4'd12, "R2");
        tick("R6");
        pulse_load(4'd0, 4'd3, 4'd13, "R7");
        tick("R6 R7");
        up = 1'b0;
        pulse_load(4'd0, 4'd5, 4'd14, "R2");
        tick("R6");

        // R2: load held across edges, data followed without a clock
        up = 1'b1;
        data_b[2] = 4'd4; data_b[1] = 4'd5; data_b[0] = 4'd6;
        load = 1'b1;
        tick("R2");
        data_b[2] = 4'd7; data_b[1] = 4'd8; data_b[0] = 4'd1;
        check_now("R2");
        load = 1'b0;
        check_now("R2");
        tick("R4");

        // R1 over R2: clear while loading, then release clear, then release load
        @(negedge clk);
        data_b[2] = 4'd3; data_b[1] = 4'd2; data_b[0] = 4'd1;
        load = 1'b1;
        check_now("R2");
        clear = 1'b1;
        check_now("R1");
        tick("R1");
        clear = 1'b0;
        check_now("R2");
        load = 1'b0;
        check_now("R2");
        tick("R4");

        #(CLK_PERIOD);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule